// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block gathers up to 32 asynchronous interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Each output is owned by a bank of registers. The two banks hold fully separate state, and each one can be programmed per line for level or edge sensing and for active-high/rising or active-low/falling polarity. Every incoming line first passes through a synchroniser. Edge events are then held in a sticky pending bit until software writes a one to that line's clear bit. A line in level mode simply reports its polarity-corrected input.

Software uses a 32-bit register bus with a word index (byte offset divided by four). It enables lines through the mask register and reads the masked status register. It services the lowest set bit, clears that bit if the line is edge-sensed, and reads status again until it is zero. The bus has no handshake: writes take effect at the clock edge where `bus_we` is high, and read data is a combinational function of the index.

Top module: `irq_dual_bank_ctrl`

## Requirements
- R1: After reset both request outputs are low, and every register in both banks reads zero.
- R2: A change on `irq_in` reaches the raw register no earlier than two clock edges later: it is not visible after one edge and is visible after two.
- R3: With mode bit 0 (level), the raw bit equals the input when polarity bit is 0 and its inverse when polarity bit is 1. It is never latched, so it drops once the input goes inactive.
- R4: With mode bit 1 (edge), a rising edge (polarity 0) or a falling edge (polarity 1) on the synchronised input sets a pending bit. That bit stays set after the input returns. The opposite edge sets nothing.
- R5: Writing the clear register (word index 2 or 10) clears the edge-pending bit of each line written as 1. Lines written as 0 keep their pending bit. Level-mode lines are unaffected.
- R6: The mask register (index 1 / 9) enables a line with 1. A pending but masked line shows in the raw register (index 0 / 8) but not in status, and does not raise the request.
- R7: Status (index 5 / 13) equals raw AND mask, and the bank's request output is high exactly when status is nonzero.
- R8: The fast bank (indices 8 to 13, byte offsets 0x20 to 0x34) has state separate from the normal bank (indices 0 to 5). A write to one bank changes no register of the other, and only the fast bank drives `fast_req`.
- R9: Indices 6, 7, 14 and 15, as well as the clear registers, read zero.
- R10: Mask (1/9), mode (3/11) and polarity (4/12) read back the last value written, so software can change a single bit by read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Asynchronous interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_widx | input | 4 | Word index: bit 3 selects fast bank, bits 2:0 select register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_widx` |
| norm_req | output | 1 | Normal-bank interrupt request |
| fast_req | output | 1 | Fast-bank interrupt request |

## Verification
The properties assume that `bus_widx` and `bus_we` are stable around the sampling edge. They also assume that, when a clear write and a fresh edge on the same line meet in one cycle, the edge is allowed to win. The bench changes inputs and bus fields only at falling clock edges, and it raises each line event several cycles away from any clear write, so no contest between set and clear ever occurs. Lines are held steady for at least three cycles so the synchroniser output settles before any check.

// File: rtl/irq_dual_bank_pkg.sv
package irq_dual_bank_pkg;
   localparam int DW = 32;
   localparam int IW = 4;
   localparam int NBANKS = 2;

   typedef enum logic [2:0] {
      SEL_RAW  = 3'd0,
      SEL_MASK = 3'd1,
      SEL_CLR  = 3'd2,
      SEL_MODE = 3'd3,
      SEL_POL  = 3'd4,
      SEL_STAT = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int NLINES = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] async_in,
   output logic [NLINES-1:0] lvl,
   output logic [NLINES-1:0] lvl_d
);
   initial begin
      if (STAGES < 2) $error("irq_sync: STAGES must be at least 2");
   end

   logic [NLINES-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign lvl = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;
   end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
   parameter int NLINES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lvl,
   input  logic [NLINES-1:0] lvl_d,
   input  logic              we_mask,
   input  logic              we_mode,
   input  logic              we_pol,
   input  logic [NLINES-1:0] clr_vec,
   input  logic [NLINES-1:0] wdata,
   output logic [NLINES-1:0] mask_q,
   output logic [NLINES-1:0] mode_q,
   output logic [NLINES-1:0] pol_q,
   output logic [NLINES-1:0] latch_q,
   output logic [NLINES-1:0] evt,
   output logic [NLINES-1:0] pend,
   output logic [NLINES-1:0] stat,
   output logic              req
);
   logic [NLINES-1:0] latch_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         mode_q <= '0;
         pol_q  <= '0;
      end else begin
         if (we_mask) mask_q <= wdata;
         if (we_mode) mode_q <= wdata;
         if (we_pol)  pol_q  <= wdata;
      end
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      logic rise_i, fall_i;
      assign rise_i     = lvl[i] & ~lvl_d[i];
      assign fall_i     = ~lvl[i] & lvl_d[i];
      assign evt[i]     = pol_q[i] ? fall_i : rise_i;
      // a fresh event beats a simultaneous clear; level lines keep no latch
      assign latch_d[i] = mode_q[i] & (evt[i] | (latch_q[i] & ~clr_vec[i]));
      assign pend[i]    = mode_q[i] ? latch_q[i] : (lvl[i] ^ pol_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else        latch_q <= latch_d;
   end

   assign stat = pend & mask_q;
   assign req  = |stat;
endmodule

// File: rtl/irq_dual_bank_ctrl.sv
module irq_dual_bank_ctrl
   import irq_dual_bank_pkg::*;
#(
   parameter int NLINES      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic              bus_we,
   input  logic [IW-1:0]     bus_widx,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              norm_req,
   output logic              fast_req
);
   initial begin
      if (NLINES < 1 || NLINES > DW) $error("irq_dual_bank_ctrl: NLINES out of range");
   end

   localparam int SELW = IW - 1;

   logic [NLINES-1:0] lvl, lvl_d;
   logic [NLINES-1:0] mask_v [NBANKS];
   logic [NLINES-1:0] mode_v [NBANKS];
   logic [NLINES-1:0] pol_v  [NBANKS];
   logic [NLINES-1:0] latch_v[NBANKS];
   logic [NLINES-1:0] evt_v  [NBANKS];
   logic [NLINES-1:0] pend_v [NBANKS];
   logic [NLINES-1:0] stat_v [NBANKS];
   logic [NLINES-1:0] clr_v  [NBANKS];
   logic              req_v  [NBANKS];

   logic              bank_sel;
   reg_sel_e          reg_sel;

   assign bank_sel = bus_widx[IW-1];
   assign reg_sel  = reg_sel_e'(bus_widx[SELW-1:0]);

   irq_sync #(.NLINES(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_in),
      .lvl      (lvl),
      .lvl_d    (lvl_d)
   );

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic hit;
      assign hit      = bus_we && (bank_sel == b[0]);
      assign clr_v[b] = (hit && reg_sel == SEL_CLR) ? bus_wdata[NLINES-1:0] : '0;

      irq_bank #(.NLINES(NLINES)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl     (lvl),
         .lvl_d   (lvl_d),
         .we_mask (hit && reg_sel == SEL_MASK),
         .we_mode (hit && reg_sel == SEL_MODE),
         .we_pol  (hit && reg_sel == SEL_POL),
         .clr_vec (clr_v[b]),
         .wdata   (bus_wdata[NLINES-1:0]),
         .mask_q  (mask_v[b]),
         .mode_q  (mode_v[b]),
         .pol_q   (pol_v[b]),
         .latch_q (latch_v[b]),
         .evt     (evt_v[b]),
         .pend    (pend_v[b]),
         .stat    (stat_v[b]),
         .req     (req_v[b])
      );
   end

   always_comb begin
      logic [NLINES-1:0] vec;
      vec = '0;
      case (reg_sel)
         SEL_RAW:  vec = pend_v[bank_sel];
         SEL_MASK: vec = mask_v[bank_sel];
         SEL_MODE: vec = mode_v[bank_sel];
         SEL_POL:  vec = pol_v[bank_sel];
         SEL_STAT: vec = stat_v[bank_sel];
         default:  vec = '0;
      endcase
      bus_rdata             = '0;
      bus_rdata[NLINES-1:0] = vec;
   end

   assign norm_req = req_v[0];
   assign fast_req = req_v[1];
endmodule

// File: rtl/irq_dual_bank_ctrl_chk.sv
module irq_dual_bank_ctrl_chk #(
   parameter int NLINES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [3:0]        bus_widx,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              norm_req,
   input logic              fast_req,
   input logic [NLINES-1:0] n_mask,
   input logic [NLINES-1:0] n_mode,
   input logic [NLINES-1:0] n_latch,
   input logic [NLINES-1:0] n_evt,
   input logic [NLINES-1:0] n_clr
);
   // R1: a cycle held in reset is followed by quiet request outputs
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!norm_req && !fast_req));

   // R6: disabling every normal line silences the normal request next cycle
   p_mask_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_widx == 4'd1 && bus_wdata == 32'd0) |=> !norm_req);

   // R5: an edge line cleared without a new event is low next cycle
   p_clear_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(n_clr & n_mode & ~n_evt)) |=> ((n_latch & $past(n_clr & n_mode & ~n_evt)) == '0));

   // R3: lines that were level-sensed hold no latched event
   p_level_unlatched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((n_latch & ~$past(n_mode)) == '0));

   // R8: fast-bank writes leave the normal mask untouched
   p_bank_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_widx[3]) |=> $stable(n_mask));

   // R9: unused word indices return zero
   p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_widx[2:0] > 3'd5) |-> (bus_rdata == 32'd0));
endmodule

bind irq_dual_bank_ctrl irq_dual_bank_ctrl_chk #(.NLINES(NLINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_widx  (bus_widx),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .norm_req  (norm_req),
   .fast_req  (fast_req),
   .n_mask    (mask_v[0]),
   .n_mode    (mode_v[0]),
   .n_latch   (latch_v[0]),
   .n_evt     (evt_v[0]),
   .n_clr     (clr_v[0])
);

// File: tb/irq_dual_bank_ctrl_bench.sv
module irq_dual_bank_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_widx = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        norm_req, fast_req;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   irq_dual_bank_ctrl u_irq_dual_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .norm_req(norm_req), .fast_req(fast_req)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_widx = idx; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [31:0] d);
      bus_widx = idx;
      #1 d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_in = '0; bus_we = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      for (int i = 0; i < 16; i++) begin
         rd(i[3:0], d);
         chk(d == 0, "R1 register zero after reset", d, 0);
      end
      chk(!norm_req && !fast_req, "R1 requests low", {30'd0, fast_req, norm_req}, 0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      do_reset();
      wr(4'd1, 32'h8);
      irq_in[3] = 1'b1;
      @(negedge clk);
      rd(4'd0, d);
      chk(d[3] == 1'b0, "R2 not visible after one edge", d, 0);
      @(negedge clk);
      rd(4'd0, d);
      chk(d[3] == 1'b1, "R2 visible after two edges", d, 32'h8);
      rd(4'd5, d);
      chk(d == 32'h8 && norm_req, "R3 active-high level status", d, 32'h8);
      irq_in[3] = 1'b0;
      cyc(3);
      rd(4'd5, d);
      chk(d == 0 && !norm_req, "R3 level not latched", d, 0);
      wr(4'd4, 32'h8);
      cyc(1);
      rd(4'd5, d);
      chk(d == 32'h8, "R3 active-low level with input low", d, 32'h8);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      do_reset();
      wr(4'd3, 32'h60);
      wr(4'd4, 32'h40);
      wr(4'd1, 32'h60);
      irq_in[5] = 1'b1;
      @(negedge clk);
      irq_in[5] = 1'b0;
      irq_in[6] = 1'b1;
      cyc(5);
      rd(4'd5, d);
      chk(d == 32'h20 && norm_req, "R4 rising edge latched, rising on falling line ignored", d, 32'h20);
      irq_in[6] = 1'b0;
      cyc(5);
      rd(4'd5, d);
      chk(d == 32'h60, "R4 falling edge latched and held", d, 32'h60);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      // continues from t_edge: lines 5 and 6 pending
      wr(4'd2, 32'h20);
      cyc(1);
      rd(4'd5, d);
      chk(d == 32'h40, "R5 clear one bit, zero bits untouched", d, 32'h40);
      wr(4'd2, 32'h40);
      cyc(1);
      rd(4'd5, d);
      chk(d == 0 && !norm_req, "R5 second clear empties status", d, 0);
      wr(4'd1, 32'h68);
      irq_in[3] = 1'b1;
      cyc(3);
      wr(4'd2, 32'h8);
      cyc(1);
      rd(4'd5, d);
      chk(d == 32'h8, "R5 clear has no effect on level line", d, 32'h8);
      rd(4'd2, d);
      chk(d == 0, "R9 clear register reads zero", d, 0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      do_reset();
      wr(4'd3, 32'h20);
      irq_in[5] = 1'b1;
      cyc(5);
      rd(4'd0, d);
      chk(d == 32'h20, "R6 masked pending visible in raw", d, 32'h20);
      rd(4'd5, d);
      chk(d == 0 && !norm_req, "R6 masked line gives no status or request", d, 0);
      wr(4'd1, 32'h20);
      cyc(1);
      rd(4'd5, d);
      chk(d == 32'h20 && norm_req, "R7 status is raw and mask, request set", d, 32'h20);
      wr(4'd1, 32'h0);
      rd(4'd5, d);
      chk(d == 0 && !norm_req, "R7 request low when status zero", {31'd0, norm_req}, 0);
   endtask

   task automatic t_banks();
      logic [31:0] d;
      do_reset();
      wr(4'd9, 32'h80);
      irq_in[7] = 1'b1;
      cyc(3);
      chk(fast_req && !norm_req, "R8 only fast request raised", {30'd0, fast_req, norm_req}, 32'h2);
      rd(4'd13, d);
      chk(d == 32'h80, "R8 fast status", d, 32'h80);
      rd(4'd1, d);
      chk(d == 0, "R8 normal mask untouched by fast write", d, 0);
      wr(4'd11, 32'h80);
      rd(4'd3, d);
      chk(d == 0, "R8 normal mode untouched by fast write", d, 0);
   endtask

   task automatic t_unused();
      logic [31:0] d;
      wr(4'd1, 32'hFFFF_FFFF);
      foreach (d[i]) begin end
      for (int k = 0; k < 4; k++) begin
         logic [3:0] idx;
         idx = (k < 2) ? 4'(6 + k) : 4'(14 + k - 2);
         rd(idx, d);
         chk(d == 0, "R9 unused index reads zero", d, 0);
      end
   endtask

   task automatic t_rmw();
      logic [31:0] d;
      do_reset();
      wr(4'd1, 32'hA5A5_0000);
      rd(4'd1, d);
      chk(d == 32'hA5A5_0000, "R10 mask readback", d, 32'hA5A5_0000);
      wr(4'd1, d | 32'h4);
      rd(4'd1, d);
      chk(d == 32'hA5A5_0004, "R10 read-modify-write sets one bit", d, 32'hA5A5_0004);
      wr(4'd12, 32'h1234_5678);
      rd(4'd12, d);
      chk(d == 32'h1234_5678, "R10 fast polarity readback", d, 32'h1234_5678);
      wr(4'd3, 32'h0F0F_0F0F);
      rd(4'd3, d);
      chk(d == 32'h0F0F_0F0F, "R10 mode readback", d, 32'h0F0F_0F0F);
   endtask

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_clear();
      t_mask();
      t_banks();
      t_unused();
      t_rmw();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule